// File: doc/BRIEF.md
# Emulated Temperature Sensor Register Block

This block is the register file that sits behind the byte-data target port of an emulated remote temperature sensor. A management controller reaches it through a plain read/write strobe interface, which stands in for the serial bus. Every access moves one byte at one register address. A thermal value arrives on an internal input and is sampled on every clock. It is coded as eight bits of whole degrees and three bits of eighths, which gives 0.000 to 255.875 degrees in 0.125-degree steps.

The temperature is split across two byte registers. To keep the two halves of one reading together, the first read of the pair stores the other half in a shadow byte, and the second read returns that shadow. A tie-off parameter selects which half comes first, and the config register reports that choice. Software can write a high threshold and a low threshold, both coded like the temperature. Two status flags record when the temperature reaches a threshold, and an active-low alert line is driven while either flag is set.

Top module: `thermreg_top`

## Requirements
- R1: While reset is held, `rd_valid` is 0, `reg_rdata` is 0x00 and `alert_n` is 1. After reset the high limit reads 0x46 at 0x07 and 0x00 at 0x13 (70.000 degrees). The low limit reads 0x00 at both 0x08 and 0x14.
- R2: A read strobe sampled at a clock edge makes `rd_valid` high for exactly the next cycle, with the addressed byte on `reg_rdata`.
- R3: Address 0x01 returns the whole degrees in binary. Address 0x10 returns the eighths in bits 7:5, with bits 4:0 always 0. For example, 25.125 degrees reads as 0x19 and 0x20.
- R4: With read order 0, a read of 0x01 returns the live whole part and stores the live eighths in a shadow byte. A later read of 0x10 returns that shadow, even if the temperature has changed in between.
- R5: With read order 1, a read of 0x10 returns the live eighths and stores the live whole part in the shadow. A later read of 0x01 returns that shadow.
- R6: Config address 0x03 reads the read-order parameter in bit 5. All other bits read 0.
- R7: The high limit is written at 0x07 (whole) and 0x13 (eighths). The low limit is written at 0x08 (whole) and 0x14 (eighths). A write to an eighths register keeps only data bits 7:5, so bits 4:0 read back as 0.
- R8: Status address 0x02 bit 4 is 1 when the sampled temperature is at or above the high limit. The flag is visible two edges after the temperature input changes.
- R9: Status bit 3 is 1 when the sampled temperature is at or below the low limit. All other status bits read 0.
- R10: `alert_n` is 0 while either status flag is set, and it returns to 1 once the temperature is back inside the limits.
- R11: Writes to 0x01, 0x02, 0x03 and 0x10 change no register. Limits, config, status and the temperature reads stay as they were.
- R12: A read of any address outside the map returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_in | input | 11 | Thermal value: whole degrees in bits 10:3, eighths in bits 2:0 |
| reg_rd | input | 1 | Read strobe, one cycle per byte |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data qualifier, high one cycle after a read strobe |
| alert_n | output | 1 | Active-low threshold alert |

## Verification
A read of the first half of the temperature pair can land in the same cycle that a new thermal sample is clocked in. The bench provokes this by changing `temp_in` at the same moment it raises the read strobe for 0x01. It then checks that the whole byte returned and the eighths read back afterwards both belong to the old sample. A third read confirms that the new sample then becomes visible. Threshold crossings are driven to exact equality and to one eighth on either side of each limit, and the status byte and `alert_n` are judged two edges after each change.

// File: rtl/thermreg_pkg.sv
package thermreg_pkg;

    localparam int WHOLE_W = 8;
    localparam int FRAC_W  = 3;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int TEMP_W  = WHOLE_W + FRAC_W;

    typedef struct packed {
        logic [WHOLE_W-1:0] whole;
        logic [FRAC_W-1:0]  frac;
    } temp_t;

    localparam logic [ADDR_W-1:0] A_TEMP_WHOLE = 8'h01;
    localparam logic [ADDR_W-1:0] A_STATUS     = 8'h02;
    localparam logic [ADDR_W-1:0] A_CONFIG     = 8'h03;
    localparam logic [ADDR_W-1:0] A_HI_WHOLE   = 8'h07;
    localparam logic [ADDR_W-1:0] A_LO_WHOLE   = 8'h08;
    localparam logic [ADDR_W-1:0] A_TEMP_FRAC  = 8'h10;
    localparam logic [ADDR_W-1:0] A_HI_FRAC    = 8'h13;
    localparam logic [ADDR_W-1:0] A_LO_FRAC    = 8'h14;

    localparam int STAT_HI_BIT   = 4;
    localparam int STAT_LO_BIT   = 3;
    localparam int CFG_ORDER_BIT = 5;

    // Eighths sit in the top bits of a byte register.
    function automatic logic [BYTE_W-1:0] frac_to_byte(input logic [FRAC_W-1:0] f);
        return {f, {(BYTE_W-FRAC_W){1'b0}}};
    endfunction

endpackage

// File: rtl/thermreg_limit.sv
module thermreg_limit
    import thermreg_pkg::*;
#(
    parameter logic [WHOLE_W-1:0] RST_WHOLE = '0,
    parameter logic [FRAC_W-1:0]  RST_FRAC  = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_whole,
    input  logic                wr_frac,
    input  logic [WHOLE_W-1:0]  whole_wdata,
    input  logic [FRAC_W-1:0]   frac_wdata,
    output temp_t               value
);

    typedef struct packed {
        temp_t lim;
    } lim_state_t;

    localparam lim_state_t LIM_RST = '{lim: '{whole: RST_WHOLE, frac: RST_FRAC}};

    lim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_whole) st_d.lim.whole = whole_wdata;
        if (wr_frac)  st_d.lim.frac  = frac_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LIM_RST;
        else        st_q <= st_d;
    end

    assign value = st_q.lim;

endmodule

// File: rtl/thermreg_compare.sv
module thermreg_compare
    import thermreg_pkg::*;
(
    input  temp_t cur,
    input  temp_t hi_lim,
    input  temp_t lo_lim,
    output logic  at_hi,
    output logic  at_lo
);

    // Whole part is the MSB field, so the packed value compares as one number.
    always_comb begin
        at_hi = (cur >= hi_lim);
        at_lo = (cur <= lo_lim);
    end

endmodule

// File: rtl/thermreg_readport.sv
module thermreg_readport
    import thermreg_pkg::*;
#(
    parameter bit READ_ORDER = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  temp_t              cur,
    input  temp_t              hi_lim,
    input  temp_t              lo_lim,
    input  logic               hi_flag,
    input  logic               lo_flag,
    output logic [BYTE_W-1:0]  rdata,
    output logic               rvalid
);

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
        logic              rvalid;
        logic [BYTE_W-1:0] shadow;
    } rp_state_t;

    localparam rp_state_t RP_RST = '0;

    rp_state_t st_d, st_q;
    logic [BYTE_W-1:0] status_byte;
    logic [BYTE_W-1:0] config_byte;
    logic [BYTE_W-1:0] cur_whole_b;
    logic [BYTE_W-1:0] cur_frac_b;
    logic              whole_first;

    always_comb begin
        status_byte = '0;
        status_byte[STAT_HI_BIT] = hi_flag;
        status_byte[STAT_LO_BIT] = lo_flag;
        config_byte = '0;
        config_byte[CFG_ORDER_BIT] = READ_ORDER;
        cur_whole_b = cur.whole;
        cur_frac_b  = frac_to_byte(cur.frac);
    end

    generate
        if (READ_ORDER) begin : g_frac_first
            assign whole_first = 1'b0;
        end else begin : g_whole_first
            assign whole_first = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd;
        st_d.rdata  = '0;
        if (rd) begin
            case (addr)
                A_TEMP_WHOLE: begin
                    if (whole_first) begin
                        st_d.rdata  = cur_whole_b;
                        st_d.shadow = cur_frac_b;
                    end else begin
                        st_d.rdata  = st_q.shadow;
                    end
                end
                A_TEMP_FRAC: begin
                    if (whole_first) begin
                        st_d.rdata  = st_q.shadow;
                    end else begin
                        st_d.rdata  = cur_frac_b;
                        st_d.shadow = cur_whole_b;
                    end
                end
                A_STATUS:   st_d.rdata = status_byte;
                A_CONFIG:   st_d.rdata = config_byte;
                A_HI_WHOLE: st_d.rdata = hi_lim.whole;
                A_HI_FRAC:  st_d.rdata = frac_to_byte(hi_lim.frac);
                A_LO_WHOLE: st_d.rdata = lo_lim.whole;
                A_LO_FRAC:  st_d.rdata = frac_to_byte(lo_lim.frac);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RP_RST;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

endmodule

// File: rtl/thermreg_top.sv
module thermreg_top
    import thermreg_pkg::*;
#(
    parameter bit                 READ_ORDER   = 1'b0,
    parameter logic [WHOLE_W-1:0] HI_RST_WHOLE = 8'd70,
    parameter logic [FRAC_W-1:0]  HI_RST_FRAC  = 3'd0,
    parameter logic [WHOLE_W-1:0] LO_RST_WHOLE = 8'd0,
    parameter logic [FRAC_W-1:0]  LO_RST_FRAC  = 3'd0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TEMP_W-1:0]          temp_in,
    input  logic                       reg_rd,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [BYTE_W-1:0]          reg_wdata,
    output logic [BYTE_W-1:0]          reg_rdata,
    output logic                       rd_valid,
    output logic                       alert_n
);

    localparam int N_LIM = 2;

    typedef struct packed {
        temp_t temp;
        logic  hi_flag;
        logic  lo_flag;
    } top_state_t;

    localparam top_state_t TOP_RST = '0;

    top_state_t st_d, st_q;
    temp_t      lim_val [N_LIM];
    temp_t      temp_q, hi_lim, lo_lim;
    logic       hi_flag_q, lo_flag_q;
    logic       cmp_hi, cmp_lo;

    localparam logic [ADDR_W-1:0] LIM_WHOLE_ADDR [N_LIM] = '{A_HI_WHOLE, A_LO_WHOLE};
    localparam logic [ADDR_W-1:0] LIM_FRAC_ADDR  [N_LIM] = '{A_HI_FRAC,  A_LO_FRAC};

    generate
        for (genvar i = 0; i < N_LIM; i++) begin : g_lim
            thermreg_limit #(
                .RST_WHOLE ((i == 0) ? HI_RST_WHOLE : LO_RST_WHOLE),
                .RST_FRAC  ((i == 0) ? HI_RST_FRAC  : LO_RST_FRAC)
            ) u_lim (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_whole    (reg_wr && (reg_addr == LIM_WHOLE_ADDR[i])),
                .wr_frac     (reg_wr && (reg_addr == LIM_FRAC_ADDR[i])),
                .whole_wdata (reg_wdata),
                .frac_wdata  (reg_wdata[BYTE_W-1 -: FRAC_W]),
                .value       (lim_val[i])
            );
        end
    endgenerate

    assign hi_lim    = lim_val[0];
    assign lo_lim    = lim_val[1];
    assign temp_q    = st_q.temp;
    assign hi_flag_q = st_q.hi_flag;
    assign lo_flag_q = st_q.lo_flag;

    thermreg_compare u_cmp (
        .cur    (temp_q),
        .hi_lim (hi_lim),
        .lo_lim (lo_lim),
        .at_hi  (cmp_hi),
        .at_lo  (cmp_lo)
    );

    always_comb begin
        st_d         = st_q;
        st_d.temp    = temp_in;
        st_d.hi_flag = cmp_hi;
        st_d.lo_flag = cmp_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TOP_RST;
        else        st_q <= st_d;
    end

    thermreg_readport #(.READ_ORDER(READ_ORDER)) u_rp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .cur     (temp_q),
        .hi_lim  (hi_lim),
        .lo_lim  (lo_lim),
        .hi_flag (hi_flag_q),
        .lo_flag (lo_flag_q),
        .rdata   (reg_rdata),
        .rvalid  (rd_valid)
    );

    assign alert_n = !(hi_flag_q || lo_flag_q);

endmodule

// File: rtl/thermreg_chk.sv
module thermreg_chk
    import thermreg_pkg::*;
#(
    parameter bit READ_ORDER = 1'b0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [BYTE_W-1:0]  reg_rdata,
    input logic               rd_valid,
    input logic               alert_n,
    input temp_t              temp_q,
    input temp_t              hi_lim,
    input temp_t              lo_lim,
    input logic               hi_flag_q,
    input logic               lo_flag_q
);

    function automatic bit is_mapped(input logic [ADDR_W-1:0] a);
        return (a == A_TEMP_WHOLE) || (a == A_STATUS) || (a == A_CONFIG) ||
               (a == A_HI_WHOLE) || (a == A_LO_WHOLE) || (a == A_TEMP_FRAC) ||
               (a == A_HI_FRAC) || (a == A_LO_FRAC);
    endfunction

    function automatic bit is_frac(input logic [ADDR_W-1:0] a);
        return (a == A_TEMP_FRAC) || (a == A_HI_FRAC) || (a == A_LO_FRAC);
    endfunction

    function automatic bit is_ro(input logic [ADDR_W-1:0] a);
        return (a == A_TEMP_WHOLE) || (a == A_STATUS) || (a == A_CONFIG) || (a == A_TEMP_FRAC);
    endfunction

    localparam logic [BYTE_W-1:0] CFG_EXP = READ_ORDER ? 8'h20 : 8'h00;

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> rd_valid); // R2
    AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(reg_rd)); // R2
    AST_FRAC_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && is_frac($past(reg_addr))) |-> (reg_rdata[4:0] == 5'd0)); // R3
    AST_CONFIG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(reg_addr) == A_CONFIG)) |-> (reg_rdata == CFG_EXP)); // R6
    AST_HI_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_q >= hi_lim) |=> hi_flag_q); // R8
    AST_HI_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_q < hi_lim) |=> !hi_flag_q); // R8
    AST_LO_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_q <= lo_lim) |=> lo_flag_q); // R9
    AST_ALERT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((temp_q < hi_lim) && (temp_q > lo_lim)) |=> alert_n); // R10
    AST_ALERT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((temp_q >= hi_lim) || (temp_q <= lo_lim)) |=> !alert_n); // R10
    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && is_ro(reg_addr)) |=> ($stable(hi_lim) && $stable(lo_lim))); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !is_mapped($past(reg_addr))) |-> (reg_rdata == 8'h00)); // R12

endmodule

bind thermreg_top thermreg_chk #(.READ_ORDER(READ_ORDER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .rd_valid  (rd_valid),
    .alert_n   (alert_n),
    .temp_q    (temp_q),
    .hi_lim    (hi_lim),
    .lo_lim    (lo_lim),
    .hi_flag_q (hi_flag_q),
    .lo_flag_q (lo_flag_q)
);

// File: tb/test_thermreg_top.sv
`timescale 1ns/1ps
module test_thermreg_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] temp_in;
    logic        rd0, rd1, wr0, wr1;
    logic [7:0]  addr, wdata;
    logic [7:0]  rdata0, rdata1;
    logic        rv0, rv1, al0, al1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] expv;
        string      req;
        int         dut;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    thermreg_top #(.READ_ORDER(1'b0)) i_thermreg_top (
        .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .reg_rd(rd0), .reg_wr(wr0),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata0), .rd_valid(rv0), .alert_n(al0)
    );

    thermreg_top #(.READ_ORDER(1'b1)) i_thermreg_top_rev (
        .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .reg_rd(rd1), .reg_wr(wr1),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata1), .rd_valid(rv1), .alert_n(al1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops scoreboard entries as read data appears.
    always @(negedge clk) begin
        if (rv0 || rv1) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected rd_valid", {30'd0, rv1, rv0}, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.dut == 0) check(rv0 && (rdata0 == it.expv), it.req, "rdata dut0", rdata0, it.expv);
                else             check(rv1 && (rdata1 == it.expv), it.req, "rdata dut1", rdata1, it.expv);
            end
        end
    end

    task automatic rd(input int dut, input logic [7:0] a, input logic [7:0] expv, input string req,
                      input bit upd = 1'b0, input logic [10:0] nt = '0);
        @(negedge clk);
        addr = a;
        if (dut == 0) rd0 = 1'b1; else rd1 = 1'b1;
        if (upd) temp_in = nt;
        sb.push_back('{expv: expv, req: req, dut: dut});
        @(negedge clk);
        check((dut == 0) ? rv0 : rv1, "R2", "rd_valid after strobe", 32'(dut == 0 ? rv0 : rv1), 32'd1);
        rd0 = 1'b0;
        rd1 = 1'b0;
        @(negedge clk);
        check(!((dut == 0) ? rv0 : rv1), "R2", "rd_valid one cycle", 32'(dut == 0 ? rv0 : rv1), 32'd0);
    endtask

    task automatic wr(input int dut, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        if (dut == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0;
        wr1 = 1'b0;
    endtask

    task automatic settemp(input logic [7:0] w, input logic [2:0] f);
        @(negedge clk);
        temp_in = {w, f};
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd0 = 0; rd1 = 0; wr0 = 0; wr1 = 0;
        addr = '0; wdata = '0; temp_in = {8'd40, 3'd0};
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        check(rv0 == 1'b0, "R1", "rd_valid in reset", rv0, 0);
        check(rdata0 == 8'h00, "R1", "rdata in reset", rdata0, 0);
        check(al0 == 1'b1, "R1", "alert_n in reset", al0, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: limit reset values
        rd(0, 8'h07, 8'h46, "R1");
        rd(0, 8'h13, 8'h00, "R1");
        rd(0, 8'h08, 8'h00, "R1");
        rd(0, 8'h14, 8'h00, "R1");
        check(al0 == 1'b1, "R10", "alert_n within limits", al0, 1);
        // R6: config bit 5 mirrors read order
        rd(0, 8'h03, 8'h00, "R6");
        rd(1, 8'h03, 8'h20, "R6");
        // R3: 25.125 degrees
        settemp(8'h19, 3'd1);
        rd(0, 8'h01, 8'h19, "R3");
        rd(0, 8'h10, 8'h20, "R3");
        // R4: whole first, shadowed eighths survive a temperature change
        settemp(8'h1E, 3'd5);
        rd(0, 8'h01, 8'h1E, "R4");
        settemp(8'h1F, 3'd2);
        rd(0, 8'h10, 8'hA0, "R4");
        rd(0, 8'h01, 8'h1F, "R4");
        rd(0, 8'h10, 8'h40, "R4");
        // R4: new sample arrives in the same cycle as the first-half read
        settemp(8'h22, 3'd6);
        rd(0, 8'h01, 8'h22, "R4", 1'b1, {8'h23, 3'd1});
        rd(0, 8'h10, 8'hC0, "R4");
        rd(0, 8'h01, 8'h23, "R4");
        rd(0, 8'h10, 8'h20, "R4");
        // R5: eighths first on the reversed instance
        settemp(8'h30, 3'd3);
        rd(1, 8'h10, 8'h60, "R5");
        settemp(8'h31, 3'd7);
        rd(1, 8'h01, 8'h30, "R5");
        rd(1, 8'h10, 8'hE0, "R5");
        rd(1, 8'h01, 8'h31, "R5");
        // R7: limit writes, eighths keep bits 7:5 only
        wr(0, 8'h07, 8'h28);
        wr(0, 8'h13, 8'hFF);
        wr(0, 8'h08, 8'h10);
        wr(0, 8'h14, 8'h5F);
        rd(0, 8'h07, 8'h28, "R7");
        rd(0, 8'h13, 8'hE0, "R7");
        rd(0, 8'h08, 8'h10, "R7");
        rd(0, 8'h14, 8'h40, "R7");
        // R8 / R10: high limit now 40.875
        settemp(8'h28, 3'd7);
        rd(0, 8'h02, 8'h10, "R8");
        check(al0 == 1'b0, "R10", "alert_n at high limit", al0, 0);
        settemp(8'h28, 3'd6);
        rd(0, 8'h02, 8'h00, "R8");
        check(al0 == 1'b1, "R10", "alert_n below high limit", al0, 1);
        settemp(8'h29, 3'd0);
        rd(0, 8'h02, 8'h10, "R8");
        // R9 / R10: low limit now 16.250
        settemp(8'h10, 3'd2);
        rd(0, 8'h02, 8'h08, "R9");
        check(al0 == 1'b0, "R10", "alert_n at low limit", al0, 0);
        settemp(8'h10, 3'd1);
        rd(0, 8'h02, 8'h08, "R9");
        settemp(8'h10, 3'd3);
        rd(0, 8'h02, 8'h00, "R9");
        check(al0 == 1'b1, "R10", "alert_n back inside", al0, 1);
        // R11: writes to read-only addresses
        wr(0, 8'h01, 8'h55);
        wr(0, 8'h02, 8'hFF);
        wr(0, 8'h03, 8'hFF);
        wr(0, 8'h10, 8'hFF);
        rd(0, 8'h03, 8'h00, "R11");
        rd(0, 8'h02, 8'h00, "R11");
        rd(0, 8'h01, 8'h10, "R11");
        rd(0, 8'h10, 8'h60, "R11");
        rd(0, 8'h07, 8'h28, "R11");
        rd(0, 8'h13, 8'hE0, "R11");
        rd(0, 8'h08, 8'h10, "R11");
        rd(0, 8'h14, 8'h40, "R11");
        // R12: unmapped addresses
        rd(0, 8'h05, 8'h00, "R12");
        rd(0, 8'h11, 8'h00, "R12");
        rd(0, 8'h7F, 8'h00, "R12");
        rd(0, 8'hFF, 8'h00, "R12");
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule